// File: doc/BRIEF.md
# Connection Memory Host Access Controller

This block connects a 16-bit host bus to the connection memory of a time-slot switch. The memory is split into four regions. Each region holds 16 streams of 128 time slots, and each entry is 32 bits wide. A 32-bit entry cannot be written in one host cycle, so the host stages the lower bytes in holding registers first. The write to the top byte or top word then carries the last piece of data and commits the whole entry in one memory write. Make and break operations are both such commits, with the entry's VALID bit (bit 31) set or clear. Query reads use the same lane decode and return one byte or one half-word of the stored entry.

Host address bit 15 turns a commit into a region-clear command instead of a memory write. The low four bits of staged byte 0 select the regions to clear (bit i selects region i). An internal sweep then visits every entry of each selected region, one entry per cycle, and clears only the VALID bit. During the sweep `busy_o` is high. Commits and queries are stalled, but staging writes still go through.

The host address is laid out as {cmd[15], region[14:13], stream[12:9], slot[8:2], lane[1:0]}. The memory address is the 13-bit value {region, stream, slot}. The attached memory returns read data one cycle after `cm_re_o`.

Top module: `cm_host_ctrl`

## Requirements
- R1: In byte mode, a write at lane 00, 01 or 10 stores D[7:0] as byte 0, 1 or 2 of the holding bytes. It is acknowledged in the same cycle, even while busy, and it causes no memory write.
- R2: A byte-mode write at lane 11 with address bit 15 clear issues one full-mask memory write of {D[7:0], byte2, byte1, byte0} to address {A[14:13], A[12:9], A[8:2]}.
- R3: In byte mode, D[15:8] has no effect on staged or committed data.
- R4: In word mode, A[1]=0 stores D[15:8] as byte 1 and D[7:0] as byte 0, in the same storage that byte mode uses. A write with A[1]=1 commits {D[15:0], byte1, byte0}.
- R5: Holding bytes keep their values after a commit.
- R6: An accepted byte-mode query returns {8'h00, entry byte[A[1:0]]} on `rdata_o`, with `rvalid_o` high in the cycle after acceptance.
- R7: An accepted word-mode query returns entry bits 15:0 when A[1]=0 and bits 31:16 when A[1]=1.
- R8: A commit with address bit 15 set writes no entry. It starts a clear of the regions whose bits are set in staged byte 0 bits 3:0. A zero mask starts nothing.
- R9: The clear writes every entry of each selected region, one per cycle, regions in ascending order and entries in ascending address order. Only bit 31 is cleared (write mask 32'h8000_0000, data 0).
- R10: `busy_o` rises in the cycle after the clear command is accepted and stays high for exactly 2048 cycles per selected region.
- R11: While `busy_o` is high, commits and queries are not acknowledged and drive no host memory access. They complete once busy ends.
- R12: After reset, `busy_o` and `rvalid_o` are low and all holding bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write request, held until acknowledged |
| rd_i | input | 1 | Host read request, held until acknowledged |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| addr_i | input | 16 | {cmd, region, stream, slot, lane} |
| wdata_i | input | 16 | Host write data |
| ack_o | output | 1 | Request accepted at this clock edge |
| rdata_o | output | 16 | Query data, valid while rvalid_o is high |
| rvalid_o | output | 1 | Query data valid |
| busy_o | output | 1 | Region clear in progress |
| cm_addr_o | output | 13 | Memory entry address |
| cm_we_o | output | 1 | Memory write strobe |
| cm_wmask_o | output | 32 | Memory bit write mask |
| cm_wdata_o | output | 32 | Memory write data |
| cm_re_o | output | 1 | Memory read strobe |
| cm_rdata_i | input | 32 | Memory read data, one cycle after cm_re_o |

## Verification
The checker assumes that the host never raises `wr_i` and `rd_i` together. It also assumes that address, data and mode stay unchanged from the moment a request is raised until `ack_o` accepts it. Under those conditions, a request seen on the bus maps directly to a memory strobe or a stall. The bench drives every access through one task per direction. That task raises a single request at a time and holds all of its fields until the edge at which the request is acknowledged.

// File: rtl/cm_host_pkg.sv
package cm_host_pkg;
  localparam int BUS_W     = 16;
  localparam int ENT_W     = 2 * BUS_W;
  localparam int VALID_BIT = ENT_W - 1;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_LOAD,
    ACC_COMMIT,
    ACC_CLEAR,
    ACC_QUERY
  } acc_e;
endpackage

// File: rtl/cm_bus_decode.sv
module cm_bus_decode
  import cm_host_pkg::*;
#(
  parameter int HA_W = 16
) (
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic            word_i,
  input  logic [HA_W-1:0] addr_i,
  input  logic            busy_i,
  output acc_e            fire_o,
  output logic            ack_o
);
  logic upper;
  acc_e kind;

  assign upper = word_i ? addr_i[1] : (addr_i[1:0] == 2'b11);

  always_comb begin
    kind = ACC_NONE;
    if (wr_i) begin
      if (!upper)              kind = ACC_LOAD;
      else if (addr_i[HA_W-1]) kind = ACC_CLEAR;
      else                     kind = ACC_COMMIT;
    end else if (rd_i) begin
      kind = ACC_QUERY;
    end
  end

  // staging never touches memory, so it may proceed during a clear
  assign ack_o  = (kind == ACC_LOAD) || ((kind != ACC_NONE) && !busy_i);
  assign fire_o = ack_o ? kind : ACC_NONE;
endmodule

// File: rtl/cm_hold_regs.sv
module cm_hold_regs
  import cm_host_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             word_i,
  input  logic [1:0]       lane_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [ENT_W-1:0] entry_o
);
  localparam int HOLD_BYTES = 3;

  logic [HOLD_BYTES-1:0][7:0] hold_q;

  for (genvar g = 0; g < HOLD_BYTES; g++) begin : g_hold
    if (g < 2) begin : g_shared
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold_q[g] <= '0;
        else if (load_i) begin
          if (word_i)                  hold_q[g] <= wdata_i[8*g +: 8];
          else if (lane_i == 2'(g))    hold_q[g] <= wdata_i[7:0];
        end
      end
    end else begin : g_byte_only
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold_q[g] <= '0;
        else if (load_i && !word_i && lane_i == 2'(g)) hold_q[g] <= wdata_i[7:0];
      end
    end
  end

  assign entry_o = word_i ? {wdata_i, hold_q[1], hold_q[0]}
                          : {wdata_i[7:0], hold_q[2], hold_q[1], hold_q[0]};
endmodule

// File: rtl/cm_sweep.sv
module cm_sweep #(
  parameter int REGIONS = 4,
  parameter int IDX_W   = 11,
  localparam int REG_W  = $clog2(REGIONS),
  localparam int EA_W   = REG_W + IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [REGIONS-1:0] mask_i,
  output logic               busy_o,
  output logic [EA_W-1:0]    addr_o
);
  logic               busy_q;
  logic [REGIONS-1:0] mask_q;
  logic [REG_W-1:0]   reg_q, first_reg, next_reg;
  logic [IDX_W-1:0]   idx_q;
  logic               next_any;

  always_comb begin
    first_reg = '0;
    for (int r = REGIONS - 1; r >= 0; r--)
      if (mask_i[r]) first_reg = REG_W'(r);
  end

  always_comb begin
    next_reg = '0;
    next_any = 1'b0;
    for (int r = REGIONS - 1; r >= 0; r--)
      if (mask_q[r] && r > int'(reg_q)) begin
        next_reg = REG_W'(r);
        next_any = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mask_q <= '0;
      reg_q  <= '0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i && |mask_i) begin
        busy_q <= 1'b1;
        mask_q <= mask_i;
        reg_q  <= first_reg;
        idx_q  <= '0;
      end
    end else if (&idx_q) begin
      idx_q <= '0;
      if (next_any) reg_q  <= next_reg;
      else          busy_q <= 1'b0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = {reg_q, idx_q};
endmodule

// File: rtl/cm_read_fmt.sv
module cm_read_fmt
  import cm_host_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             re_i,
  input  logic             word_i,
  input  logic [1:0]       lane_i,
  input  logic [ENT_W-1:0] cm_rdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             rvalid_o
);
  logic       rvalid_q, word_q;
  logic [1:0] lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      word_q   <= 1'b0;
      lane_q   <= '0;
    end else begin
      rvalid_q <= re_i;
      if (re_i) begin
        word_q <= word_i;
        lane_q <= lane_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rvalid_q) begin
      if (word_q) rdata_o = lane_q[1] ? cm_rdata_i[ENT_W-1:BUS_W] : cm_rdata_i[BUS_W-1:0];
      else        rdata_o = {{(BUS_W-8){1'b0}}, cm_rdata_i[8*lane_q +: 8]};
    end
  end

  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/cm_host_ctrl.sv
module cm_host_ctrl
  import cm_host_pkg::*;
#(
  parameter int REGIONS  = 4,
  parameter int STREAMS  = 16,
  parameter int SLOTS    = 128,
  localparam int REG_W   = $clog2(REGIONS),
  localparam int IDX_W   = $clog2(STREAMS) + $clog2(SLOTS),
  localparam int EA_W    = REG_W + IDX_W,
  localparam int HA_W    = EA_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             word_i,
  input  logic [HA_W-1:0]  addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             ack_o,
  output logic [BUS_W-1:0] rdata_o,
  output logic             rvalid_o,
  output logic             busy_o,
  output logic [EA_W-1:0]  cm_addr_o,
  output logic             cm_we_o,
  output logic [ENT_W-1:0] cm_wmask_o,
  output logic [ENT_W-1:0] cm_wdata_o,
  output logic             cm_re_o,
  input  logic [ENT_W-1:0] cm_rdata_i
);
  localparam logic [ENT_W-1:0] VALID_MASK = ENT_W'(1) << VALID_BIT;

  acc_e             fire;
  logic             busy;
  logic [EA_W-1:0]  sweep_addr;
  logic [ENT_W-1:0] entry;

  cm_bus_decode #(.HA_W(HA_W)) u_dec (
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .word_i (word_i),
    .addr_i (addr_i),
    .busy_i (busy),
    .fire_o (fire),
    .ack_o  (ack_o)
  );

  cm_hold_regs u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (fire == ACC_LOAD),
    .word_i  (word_i),
    .lane_i  (addr_i[1:0]),
    .wdata_i (wdata_i),
    .entry_o (entry)
  );

  cm_sweep #(.REGIONS(REGIONS), .IDX_W(IDX_W)) u_sweep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fire == ACC_CLEAR),
    .mask_i  (entry[REGIONS-1:0]),
    .busy_o  (busy),
    .addr_o  (sweep_addr)
  );

  cm_read_fmt u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .re_i       (fire == ACC_QUERY),
    .word_i     (word_i),
    .lane_i     (addr_i[1:0]),
    .cm_rdata_i (cm_rdata_i),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  // the sweep owns the memory port while busy; host commits are stalled then
  assign cm_we_o    = busy || (fire == ACC_COMMIT);
  assign cm_addr_o  = busy ? sweep_addr : addr_i[HA_W-2:2];
  assign cm_wmask_o = busy ? VALID_MASK : '1;
  assign cm_wdata_o = busy ? '0 : entry;
  assign cm_re_o    = (fire == ACC_QUERY);
  assign busy_o     = busy;
endmodule

// File: rtl/cm_host_ctrl_chk.sv
module cm_host_ctrl_chk #(
  parameter int HA_W  = 16,
  parameter int EA_W  = 13,
  parameter int IDX_W = 11,
  parameter int ENT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             rd_i,
  input logic             word_i,
  input logic [HA_W-1:0]  addr_i,
  input logic             ack_o,
  input logic             rvalid_o,
  input logic             busy_o,
  input logic [EA_W-1:0]  cm_addr_o,
  input logic             cm_we_o,
  input logic [ENT_W-1:0] cm_wmask_o,
  input logic             cm_re_o
);
  localparam logic [ENT_W-1:0] VMASK = {1'b1, {(ENT_W-1){1'b0}}};

  logic        upper;
  logic [31:0] run_q;

  assign upper = word_i ? addr_i[1] : (addr_i[1:0] == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  assert_stage_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !upper && !busy_o) |-> !cm_we_o);

  assert_commit_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ack_o && upper && !addr_i[HA_W-1]) |->
      (cm_we_o && cm_wmask_o == '1 && cm_addr_o == addr_i[HA_W-2:2]));

  assert_query_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_re_o |=> rvalid_o);

  assert_valid_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(cm_re_o));

  assert_clear_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ack_o && upper && addr_i[HA_W-1]) |-> !cm_we_o);

  assert_sweep_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cm_we_o && cm_wmask_o == VMASK));

  assert_busy_length_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q[IDX_W-1:0] == '0 && run_q != 0));

  assert_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (rd_i || (wr_i && upper))) |-> !ack_o);

  assert_no_read_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cm_re_o);
endmodule

bind cm_host_ctrl cm_host_ctrl_chk #(
  .HA_W(HA_W), .EA_W(EA_W), .IDX_W(IDX_W), .ENT_W(cm_host_pkg::ENT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .word_i     (word_i),
  .addr_i     (addr_i),
  .ack_o      (ack_o),
  .rvalid_o   (rvalid_o),
  .busy_o     (busy_o),
  .cm_addr_o  (cm_addr_o),
  .cm_we_o    (cm_we_o),
  .cm_wmask_o (cm_wmask_o),
  .cm_re_o    (cm_re_o)
);

// File: tb/tb_cm_host_ctrl.sv
`timescale 1ns/1ps
module tb_cm_host_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0, word_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic        ack_o, rvalid_o, busy_o, cm_we_o, cm_re_o;
  logic [15:0] rdata_o;
  logic [12:0] cm_addr_o;
  logic [31:0] cm_wmask_o, cm_wdata_o;
  logic [31:0] cm_rdata_i = '0;

  int n_chk = 0, n_fail = 0, n_wr = 0, sweep_err = 0;
  logic [31:0] mem [int];
  logic [31:0] refm [int];
  logic [7:0]  hb [3];
  logic [12:0] sweep_exp;
  logic [3:0]  sweep_mask;
  logic        sweep_on = 1'b0;

  always #4 clk_i = ~clk_i;

  cm_host_ctrl dut (.*);

  // attached memory model
  always @(posedge clk_i) begin
    if (cm_re_o) cm_rdata_i <= mem.exists(int'(cm_addr_o)) ? mem[int'(cm_addr_o)] : 32'h0;
    if (cm_we_o) begin
      logic [31:0] old;
      old = mem.exists(int'(cm_addr_o)) ? mem[int'(cm_addr_o)] : 32'h0;
      mem[int'(cm_addr_o)] = (old & ~cm_wmask_o) | (cm_wdata_o & cm_wmask_o);
      n_wr++;
    end
  end

  // R9: sweep order monitor
  always @(posedge clk_i) begin
    if (busy_o && sweep_on) begin
      if (cm_addr_o !== sweep_exp || cm_wmask_o !== 32'h8000_0000 || cm_wdata_o !== 32'h0) sweep_err++;
      if (&sweep_exp[10:0]) begin
        logic found;
        found = 1'b0;
        for (int r = 0; r < 4; r++)
          if (!found && sweep_mask[r] && r > int'(sweep_exp[12:11])) begin
            sweep_exp = {2'(r), 11'h0};
            found = 1'b1;
          end
      end else sweep_exp = sweep_exp + 1'b1;
    end
  end

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=%0d exp=done", n_chk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ha(bit clr, logic [1:0] rg, logic [3:0] st, logic [6:0] sl, logic [1:0] ln);
    return {clr, rg, st, sl, ln};
  endfunction

  function automatic logic [31:0] ref_get(int a);
    return refm.exists(a) ? refm[a] : 32'h0;
  endfunction

  function automatic logic [15:0] exp_query(bit w, logic [1:0] ln, logic [31:0] e);
    if (w) return ln[1] ? e[31:16] : e[15:0];
    return {8'h00, e[8*ln +: 8]};
  endfunction

  task automatic do_wr(bit w, logic [15:0] a, logic [15:0] d, output int waits);
    @(negedge clk_i);
    wr_i = 1'b1; word_i = w; addr_i = a; wdata_i = d; waits = 0;
    #1;
    while (!ack_o) begin @(negedge clk_i); #1; waits++; end
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic do_rd(bit w, logic [15:0] a, output logic [15:0] q, output int waits);
    @(negedge clk_i);
    rd_i = 1'b1; word_i = w; addr_i = a; waits = 0;
    #1;
    while (!ack_o) begin @(negedge clk_i); #1; waits++; end
    @(posedge clk_i); #1;
    rd_i = 1'b0;
    @(negedge clk_i);
    check("R6", "rvalid after query", 32'(rvalid_o), 32'h1);
    q = rdata_o;
  endtask

  // bus write plus reference model of holding bytes and commits
  task automatic bw(bit w, logic [15:0] a, logic [15:0] d, output int waits);
    do_wr(w, a, d, waits);
    if (w) begin
      if (!a[1]) begin hb[1] = d[15:8]; hb[0] = d[7:0]; end
      else if (!a[15]) refm[int'(a[14:2])] = {d, hb[1], hb[0]};
    end else begin
      if (a[1:0] != 2'b11) hb[a[1:0]] = d[7:0];
      else if (!a[15]) refm[int'(a[14:2])] = {d[7:0], hb[2], hb[1], hb[0]};
    end
  endtask

  task automatic make_byte(logic [12:0] ea, logic [31:0] e, logic [7:0] junk);
    int wt;
    for (int l = 0; l < 4; l++) bw(1'b0, {1'b0, ea, 2'(l)}, {junk, e[8*l +: 8]}, wt);
  endtask

  task automatic make_word(logic [12:0] ea, logic [31:0] e);
    int wt;
    bw(1'b1, {1'b0, ea, 2'b00}, e[15:0], wt);
    bw(1'b1, {1'b0, ea, 2'b10}, e[31:16], wt);
  endtask

  task automatic verify_entry(string req, int a);
    logic [15:0] q;
    int wt;
    check(req, $sformatf("mem[%0h]", a), mem.exists(a) ? mem[a] : 32'h0, ref_get(a));
    do_rd(1'b1, {1'b0, 13'(a), 2'b10}, q, wt);
    check(req, "word query hi", 32'(q), 32'(exp_query(1'b1, 2'b10, ref_get(a))));
  endtask

  task automatic apply_clear_ref(logic [3:0] m);
    foreach (refm[k]) if (m[k >> 11]) refm[k][31] = 1'b0;
  endtask

  initial begin
    int wt, cnt, w0;
    logic [15:0] q;
    logic [12:0] ea;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) hb[i] = 8'h00;

    // R12 reset state
    repeat (3) @(negedge clk_i);
    check("R12", "busy during reset", 32'(busy_o), 32'h0);
    check("R12", "rvalid during reset", 32'(rvalid_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R12", "busy after reset", 32'(busy_o), 32'h0);
    check("R12", "no memory access after reset", 32'(n_wr), 32'h0);

    // R12 + R3: commit straight away uses zeroed holding bytes, upper bus byte ignored
    bw(1'b0, ha(0, 2'd1, 4'd3, 7'd5, 2'b11), 16'hC35A, wt);
    check("R12", "holding zero at commit", mem[int'({2'd1, 4'd3, 7'd5})], 32'h5A00_0000);

    // R1 staging makes no writes
    w0 = n_wr;
    bw(1'b0, ha(0, 2'd0, 4'd1, 7'd2, 2'b00), 16'hFF11, wt);
    bw(1'b0, ha(0, 2'd0, 4'd1, 7'd2, 2'b01), 16'hEE22, wt);
    bw(1'b0, ha(0, 2'd0, 4'd1, 7'd2, 2'b10), 16'hDD33, wt);
    check("R1", "writes during staging", 32'(n_wr - w0), 32'h0);
    check("R1", "staging ack without wait", 32'(wt), 32'h0);
    // R2 + R3 commit
    bw(1'b0, ha(0, 2'd0, 4'd1, 7'd2, 2'b11), 16'hCC44, wt);
    check("R2", "byte commit entry", mem[int'({2'd0, 4'd1, 7'd2})], 32'h4433_2211);
    check("R2", "single write", 32'(n_wr - w0), 32'h1);

    // R5 holding retained: rewrite only byte 3 at a new address
    bw(1'b0, ha(0, 2'd2, 4'd9, 7'd100, 2'b11), 16'h0080, wt);
    check("R5", "retained bytes", mem[int'({2'd2, 4'd9, 7'd100})], 32'h8033_2211);

    // R4 word make, then shared storage with byte commit
    make_word({2'd3, 4'd15, 7'd127}, 32'hDEAD_BEEF);
    check("R4", "word commit", mem[int'({2'd3, 4'd15, 7'd127})], 32'hDEAD_BEEF);
    bw(1'b1, ha(0, 2'd3, 4'd0, 7'd0, 2'b00), 16'hA1B2, wt);
    bw(1'b0, ha(0, 2'd3, 4'd0, 7'd0, 2'b11), 16'h0077, wt);
    check("R4", "word-staged bytes in byte commit", mem[int'({2'd3, 4'd0, 7'd0})], 32'h7733_A1B2);

    // R6 / R7 queries on every lane
    for (int l = 0; l < 4; l++) begin
      do_rd(1'b0, ha(0, 2'd3, 4'd15, 7'd127, 2'(l)), q, wt);
      check("R6", $sformatf("byte query lane %0d", l), 32'(q), 32'(exp_query(1'b0, 2'(l), 32'hDEAD_BEEF)));
    end
    do_rd(1'b1, ha(0, 2'd3, 4'd15, 7'd127, 2'b00), q, wt);
    check("R7", "word query lo", 32'(q), 32'hBEEF);
    do_rd(1'b1, ha(0, 2'd3, 4'd15, 7'd127, 2'b10), q, wt);
    check("R7", "word query hi", 32'(q), 32'hDEAD);

    // constrained random makes, breaks and queries over a small address pool
    for (int i = 0; i < 120; i++) begin
      logic [15:0] a, d;
      bit w;
      w = 1'($urandom_range(0, 1));
      a = {1'b0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 3)), 7'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      d = 16'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        do_rd(w, a, q, wt);
        check(w ? "R7" : "R6", "random query", 32'(q), 32'(exp_query(w, a[1:0], ref_get(int'(a[14:2])))));
      end else begin
        bw(w, a, d, wt);
        if ((w && a[1]) || (!w && a[1:0] == 2'b11))
          check(w ? "R4" : "R2", "random commit", mem[int'(a[14:2])], ref_get(int'(a[14:2])));
      end
    end

    // valid entries in every region for the clear tests
    for (int r = 0; r < 4; r++) begin
      make_byte({2'(r), 4'd7, 7'd9}, 32'h8000_0000 | 32'(r * 32'h0101_0101 + 32'h0012_3456), 8'hA5);
      make_word({2'(r), 4'd0, 7'd127}, 32'hFFFF_FFFF);
    end

    // R8 zero mask: nothing happens
    w0 = n_wr;
    bw(1'b1, ha(0, 2'd0, 4'd0, 7'd0, 2'b00), 16'h00F0, wt);
    bw(1'b1, ha(1, 2'd0, 4'd0, 7'd0, 2'b10), 16'h0000, wt);
    @(negedge clk_i);
    check("R8", "zero mask busy", 32'(busy_o), 32'h0);
    check("R8", "zero mask writes", 32'(n_wr - w0), 32'h0);

    // R8/R9/R10/R11 word-issued clear of regions 0 and 2
    bw(1'b1, ha(0, 2'd0, 4'd0, 7'd0, 2'b00), 16'h0005, wt);
    w0 = n_wr;
    sweep_exp = 13'h0000; sweep_mask = 4'b0101; sweep_on = 1'b1;
    bw(1'b1, ha(1, 2'd3, 4'd3, 7'd3, 2'b10), 16'h1234, wt);
    check("R8", "clear command writes no entry", 32'(n_wr - w0), 32'h0);
    apply_clear_ref(4'b0101);
    cnt = 0;
    @(negedge clk_i);
    while (busy_o) begin cnt++; @(negedge clk_i); end
    check("R10", "busy cycles two regions", 32'(cnt), 32'd4096);
    check("R9", "sweep write sequence errors", 32'(sweep_err), 32'h0);
    check("R9", "sweep write count", 32'(n_wr - w0), 32'd4096);
    foreach (refm[k]) verify_entry("R9", k);

    // byte-issued clear of region 3, with stalls during busy
    for (int l = 0; l < 3; l++) bw(1'b0, ha(0, 2'd0, 4'd0, 7'd0, 2'(l)), (l == 0) ? 16'hFF08 : 16'h0000, wt);
    sweep_exp = {2'd3, 11'h0}; sweep_mask = 4'b1000; sweep_err = 0;
    bw(1'b0, ha(1, 2'd0, 4'd0, 7'd0, 2'b11), 16'h0000, wt);
    apply_clear_ref(4'b1000);
    repeat (10) @(negedge clk_i);
    bw(1'b0, ha(0, 2'd1, 4'd1, 7'd1, 2'b01), 16'h0066, wt);
    check("R1", "staging during busy not stalled", 32'(wt), 32'h0);
    ea = {2'd1, 4'd1, 7'd1};
    bw(1'b0, {1'b0, ea, 2'b11}, 16'h0099, wt);
    check("R11", "commit stalled until idle", 32'(wt > 1000), 32'h1);
    check("R11", "busy low once commit accepted", 32'(busy_o), 32'h0);
    check("R11", "stalled commit data", mem[int'(ea)], ref_get(int'(ea)));
    check("R9", "byte clear sequence errors", 32'(sweep_err), 32'h0);
    check("R8", "byte0 mask from byte writes", mem[int'({2'd3, 4'd0, 7'd127})], 32'h7FFF_FFFF);

    // R11 query stalled behind a clear of region 1
    bw(1'b0, ha(0, 2'd0, 4'd0, 7'd0, 2'b00), 16'h0002, wt);
    sweep_exp = {2'd1, 11'h0}; sweep_mask = 4'b0010; sweep_err = 0;
    bw(1'b0, ha(1, 2'd0, 4'd0, 7'd0, 2'b11), 16'h0000, wt);
    apply_clear_ref(4'b0010);
    do_rd(1'b1, ha(0, 2'd1, 4'd7, 7'd9, 2'b10), q, wt);
    check("R11", "query stalled", 32'(wt > 1000), 32'h1);
    check("R11", "query after clear", 32'(q), 32'(ref_get(int'({2'd1, 4'd7, 7'd9})) >> 16));
    check("R9", "region 1 sequence errors", 32'(sweep_err), 32'h0);
    sweep_on = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule